// File: doc/BRIEF.md
# Configuration Array Programming Controller

This block sits behind a boundary-scan test access port and turns the instruction held in the port's instruction register into operations on a small nonvolatile configuration store. The store is a set of columns. The controller holds an address register that picks a column and a column-wide data register. It also holds a user signature word, a programming-mode flag, a read-protection fuse and a DONE bit. The TAP state machine stays outside the block. It supplies the capture, shift and run-test-idle indications, the serial input and the current opcode. The block returns the serial output.

Data registers are loaded and unloaded through the usual capture and shift states. Action commands fire when the port enters run-test-idle. These commands are program, verify, erase and the flag and fuse operations. Every command that alters or reads the store is refused unless programming mode is active. Programming writes into the store as a bitwise AND, so an erased bit (1) can only be cleared until the next bulk erase. When the fuse is set, verify reads back nothing. The DONE bit drives the config-valid output that releases normal device operation.

Top module: `cfg_prog_ctrl`

## Requirements
- R1: After reset, cfg_valid, read_prot and prog_mode are 0, the address and data registers are 0, and every stored column and the stored user signature are all ones.
- R2: An action command executes once, at the rising clock edge of the first cycle in which rti is 1 after a cycle with rti at 0. Its result shows at the outputs after that edge. Further cycles with rti held at 1 do nothing, even if ir_code changes. Opcodes: enable 8'h10, disable 8'h11, bulk erase 8'h12, address shift 8'h20, data shift 8'h21, program 8'h30, program+increment 8'h31, verify 8'h32, verify+increment 8'h33, set fuse 8'h34, program signature 8'h35, signature access 8'h36, clear DONE 8'h40, set DONE 8'h41.
- R3: Opcode 8'h10 sets prog_mode and 8'h11 clears it. While prog_mode is 0, program, program+increment, verify, verify+increment, set fuse, program signature and bulk erase have no effect.
- R4: Under opcode 8'h20 the 10-bit address register shifts one bit per shift_dr cycle toward bit 0. tdi enters bit 9 and tdo shows bit 0, so the old address leaves LSB first while the new one enters.
- R5: Under opcode 8'h21 the 43-bit data register shifts in the same way, with tdi entering bit 42. Program writes the stored column at the current address as (old AND data register).
- R6: Verify copies the addressed column into the data register. For an address at or above the column count, program changes nothing and verify loads all zeros.
- R7: Program+increment and verify+increment perform the plain operation and then add one to the address. Past the last column (63 by default) the address wraps to 0.
- R8: Under opcode 8'h36 or 8'h35, capture loads the 32-bit signature shift register from the stored signature, and shift_dr moves it LSB first with tdi entering bit 31. Program signature ANDs the shift register into the stored signature.
- R9: Set fuse drives read_prot to 1. While it is 1, verify loads all zeros, but the stored signature can still be read through opcode 8'h36.
- R10: Bulk erase sets every column and the stored signature to all ones and clears the fuse and DONE. No other command clears the fuse.
- R11: Set DONE raises cfg_valid and clear DONE lowers it. Neither touches anything else, and neither needs programming mode.
- R12: Any opcode other than 8'h20, 8'h21, 8'h35 and 8'h36 selects a 1-bit bypass register for scanning. Capture loads it with 0 and each shift loads it with tdi.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_code | input | 8 | Current instruction register contents |
| cap_dr | input | 1 | TAP is in the data-register capture state |
| shift_dr | input | 1 | TAP is in the data-register shift state |
| rti | input | 1 | TAP is in run-test-idle |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, LSB of the selected register |
| cfg_valid | output | 1 | DONE bit; normal operation enabled |
| read_prot | output | 1 | Read-protection fuse state |
| prog_mode | output | 1 | Programming mode is active |

## Verification
Flags and fuse changes from an action command appear one edge after the run-test-idle cycle that fires it. The bench drives inputs on the falling edge and reads the outputs on the next falling edge. It also reads cfg_valid before that edge to confirm nothing moves early. In a scan, the first tdo bit is already due from the capture edge, and each later bit appears one edge after the bit before it. The scan task therefore samples tdo at each falling edge before the shift edge. Stored data can only be observed through a verify followed by a data scan, so every column check is a program, verify and scan sequence with the result computed as an AND in the bench.

// File: rtl/cfg_prog_ctrl.sv
module cfg_prog_ctrl #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 43,
  parameter int SIG_W  = 32,
  parameter int COLS   = 64,
  parameter logic [7:0] OP_PROG_EN    = 8'h10,
  parameter logic [7:0] OP_PROG_DIS   = 8'h11,
  parameter logic [7:0] OP_BULK_ERASE = 8'h12,
  parameter logic [7:0] OP_ADDR_SHIFT = 8'h20,
  parameter logic [7:0] OP_DATA_SHIFT = 8'h21,
  parameter logic [7:0] OP_PROGRAM    = 8'h30,
  parameter logic [7:0] OP_PROG_INC   = 8'h31,
  parameter logic [7:0] OP_VERIFY     = 8'h32,
  parameter logic [7:0] OP_VERIFY_INC = 8'h33,
  parameter logic [7:0] OP_SET_FUSE   = 8'h34,
  parameter logic [7:0] OP_PROG_SIG   = 8'h35,
  parameter logic [7:0] OP_SIG_ACCESS = 8'h36,
  parameter logic [7:0] OP_CLR_DONE   = 8'h40,
  parameter logic [7:0] OP_SET_DONE   = 8'h41
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] ir_code,
  input  logic       cap_dr,
  input  logic       shift_dr,
  input  logic       rti,
  input  logic       tdi,
  output logic       tdo,
  output logic       cfg_valid,
  output logic       read_prot,
  output logic       prog_mode
);
  localparam int IDX_W = (COLS > 1) ? $clog2(COLS) : 1;

  logic [DATA_W-1:0] mem [COLS];
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data_sr;
  logic [SIG_W-1:0]  sig_sr, sig_nv;
  logic              fuse, done, pmode, rti_q, byp;

  logic sel_addr, sel_data, sel_sig, byp_sel, exec, hit;
  logic is_prog, is_verify, do_inc;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] addr_next;

  assign sel_addr  = (ir_code == OP_ADDR_SHIFT);
  assign sel_data  = (ir_code == OP_DATA_SHIFT);
  assign sel_sig   = (ir_code == OP_SIG_ACCESS) || (ir_code == OP_PROG_SIG);
  assign byp_sel   = !(sel_addr || sel_data || sel_sig);
  assign exec      = rti && !rti_q;
  assign hit       = (addr < ADDR_W'(COLS));
  assign idx       = addr[IDX_W-1:0];
  assign addr_next = (addr >= ADDR_W'(COLS - 1)) ? '0 : addr + 1'b1;
  assign is_prog   = (ir_code == OP_PROGRAM) || (ir_code == OP_PROG_INC);
  assign is_verify = (ir_code == OP_VERIFY)  || (ir_code == OP_VERIFY_INC);
  assign do_inc    = (ir_code == OP_PROG_INC) || (ir_code == OP_VERIFY_INC);

  assign tdo = sel_addr ? addr[0] :
               sel_data ? data_sr[0] :
               sel_sig  ? sig_sr[0] : byp;

  assign cfg_valid = done;
  assign read_prot = fuse;
  assign prog_mode = pmode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < COLS; c++) mem[c] <= '1;
    end else if (exec && pmode) begin
      if (ir_code == OP_BULK_ERASE) begin
        for (int c = 0; c < COLS; c++) mem[c] <= '1;
      end else if (is_prog && hit) begin
        mem[idx] <= mem[idx] & data_sr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr    <= '0;
      data_sr <= '0;
      sig_sr  <= '0;
      sig_nv  <= '1;
      fuse    <= 1'b0;
      done    <= 1'b0;
      pmode   <= 1'b0;
      rti_q   <= 1'b0;
      byp     <= 1'b0;
    end else begin
      rti_q <= rti;
      if (cap_dr) begin
        if (sel_sig) sig_sr <= sig_nv;
        if (byp_sel) byp <= 1'b0;
      end
      if (shift_dr) begin
        if (sel_addr) addr    <= {tdi, addr[ADDR_W-1:1]};
        if (sel_data) data_sr <= {tdi, data_sr[DATA_W-1:1]};
        if (sel_sig)  sig_sr  <= {tdi, sig_sr[SIG_W-1:1]};
        if (byp_sel)  byp     <= tdi;
      end
      if (exec) begin
        if (ir_code == OP_PROG_EN)  pmode <= 1'b1;
        if (ir_code == OP_PROG_DIS) pmode <= 1'b0;
        if (ir_code == OP_SET_DONE) done  <= 1'b1;
        if (ir_code == OP_CLR_DONE) done  <= 1'b0;
        if (pmode) begin
          if (ir_code == OP_BULK_ERASE) begin
            sig_nv <= '1;
            fuse   <= 1'b0;
            done   <= 1'b0;
          end
          if (ir_code == OP_SET_FUSE) fuse <= 1'b1;
          if (ir_code == OP_PROG_SIG) sig_nv <= sig_nv & sig_sr;
          if (is_verify) data_sr <= (fuse || !hit) ? '0 : mem[idx];
          if (do_inc) addr <= addr_next;
        end
      end
    end
  end
endmodule

// File: rtl/cfg_prog_ctrl_chk.sv
module cfg_prog_ctrl_chk #(
  parameter int DATA_W = 43,
  parameter logic [7:0] OP_PROG_EN    = 8'h10,
  parameter logic [7:0] OP_BULK_ERASE = 8'h12,
  parameter logic [7:0] OP_VERIFY     = 8'h32,
  parameter logic [7:0] OP_VERIFY_INC = 8'h33,
  parameter logic [7:0] OP_SET_DONE   = 8'h41
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        ir_code,
  input logic              shift_dr,
  input logic              tdi,
  input logic              tdo,
  input logic              cfg_valid,
  input logic              read_prot,
  input logic              prog_mode,
  input logic              exec,
  input logic              byp_sel,
  input logic [DATA_W-1:0] data_sr
);
  assert_exec_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exec |=> !exec);

  assert_mode_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_mode) |-> $past(exec && ir_code == OP_PROG_EN));

  assert_fuse_needs_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(read_prot) |-> $past(prog_mode));

  assert_secure_verify_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && prog_mode && read_prot && (ir_code == OP_VERIFY || ir_code == OP_VERIFY_INC))
      |=> (data_sr == '0));

  assert_fuse_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(read_prot) |-> $past(exec && prog_mode && ir_code == OP_BULK_ERASE));

  assert_done_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_valid) |-> $past(exec && ir_code == OP_SET_DONE));

  assert_bypass_delay_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_dr && byp_sel) |=> (!byp_sel || tdo == $past(tdi)));
endmodule

bind cfg_prog_ctrl cfg_prog_ctrl_chk #(
  .DATA_W(DATA_W), .OP_PROG_EN(OP_PROG_EN), .OP_BULK_ERASE(OP_BULK_ERASE),
  .OP_VERIFY(OP_VERIFY), .OP_VERIFY_INC(OP_VERIFY_INC), .OP_SET_DONE(OP_SET_DONE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ir_code(ir_code), .shift_dr(shift_dr), .tdi(tdi),
  .tdo(tdo), .cfg_valid(cfg_valid), .read_prot(read_prot), .prog_mode(prog_mode),
  .exec(exec), .byp_sel(byp_sel), .data_sr(data_sr)
);

// File: tb/sim_cfg_prog_ctrl.sv
module sim_cfg_prog_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] EN = 8'h10, DIS = 8'h11, BULK = 8'h12, ASH = 8'h20, DSH = 8'h21,
    PRG = 8'h30, PRGI = 8'h31, VFY = 8'h32, VFYI = 8'h33, FUSE = 8'h34, PSIG = 8'h35,
    SIG = 8'h36, CDONE = 8'h40, SDONE = 8'h41;
  localparam logic [63:0] ONES43 = 64'h7FF_FFFF_FFFF;
  localparam logic [63:0] ONES32 = 64'hFFFF_FFFF;

  logic clk = 0, rst_n = 0, cap_dr = 0, shift_dr = 0, rti = 0, tdi = 0;
  logic [7:0] ir_code = 8'hFF;
  logic tdo, cfg_valid, read_prot, prog_mode;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_prog_ctrl u0 (.clk(clk), .rst_n(rst_n), .ir_code(ir_code), .cap_dr(cap_dr),
    .shift_dr(shift_dr), .rti(rti), .tdi(tdi), .tdo(tdo), .cfg_valid(cfg_valid),
    .read_prot(read_prot), .prog_mode(prog_mode));

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic run_op(input logic [7:0] op);
    @(negedge clk); ir_code = op; rti = 1;
    @(negedge clk); rti = 0;
  endtask

  task automatic scan(input logic [7:0] op, input int width, input logic [63:0] din,
                      output logic [63:0] dout);
    dout = '0;
    @(negedge clk); ir_code = op; cap_dr = 1;
    @(negedge clk); cap_dr = 0; shift_dr = 1;
    for (int i = 0; i < width; i++) begin
      tdi = din[i];
      dout[i] = tdo;
      @(negedge clk);
    end
    shift_dr = 0; tdi = 0;
  endtask

  task automatic read_col(input logic [9:0] a, output logic [63:0] v);
    logic [63:0] d;
    scan(ASH, 10, {54'd0, a}, d);
    run_op(VFY);
    scan(DSH, 43, 64'd0, v);
  endtask

  task automatic write_col(input logic [9:0] a, input logic [63:0] v, input logic [7:0] op);
    logic [63:0] d;
    scan(ASH, 10, {54'd0, a}, d);
    scan(DSH, 43, v, d);
    run_op(op);
  endtask

  task automatic t_reset;
    chk("R1 cfg_valid", cfg_valid, 0);
    chk("R1 read_prot", read_prot, 0);
    chk("R1 prog_mode", prog_mode, 0);
  endtask

  task automatic t_gate;
    logic [63:0] v;
    write_col(10'd5, 64'h0F, PRG);
    run_op(FUSE);
    chk("R3 fuse ignored", read_prot, 0);
    run_op(EN);
    chk("R3 enter mode", prog_mode, 1);
    read_col(10'd5, v);
    chk("R3 program ignored / R1 erased", v, ONES43);
  endtask

  task automatic t_prog;
    logic [63:0] v, a;
    logic [63:0] p1 = 64'h123_4567_89AB, p2 = 64'h7F0_F0F0_FF00;
    write_col(10'd5, p1, PRG);
    read_col(10'd5, v);
    chk("R5 R6 program/verify", v, p1);
    write_col(10'd5, p2, PRG);
    read_col(10'd5, v);
    chk("R5 AND write", v, p1 & p2);
    scan(ASH, 10, 64'd0, a);
    chk("R4 address readback", a, 64'd5);
  endtask

  task automatic t_incr;
    logic [63:0] v, a, d;
    write_col(10'd10, 64'h0AA_AAAA_AAAA, PRGI);
    scan(DSH, 43, 64'h555_5555_5555, d);
    run_op(PRG);
    scan(ASH, 10, 64'd10, a);
    chk("R7 program+inc address", a, 64'd11);
    run_op(VFYI);
    scan(DSH, 43, 64'd0, v);
    chk("R7 verify+inc data", v, 64'h0AA_AAAA_AAAA);
    run_op(VFY);
    scan(DSH, 43, 64'd0, v);
    chk("R7 write after inc", v, 64'h555_5555_5555);
    scan(ASH, 10, 64'd63, a);
    run_op(VFYI);
    scan(ASH, 10, 64'd0, a);
    chk("R7 wrap to zero", a, 64'd0);
  endtask

  task automatic t_range;
    logic [63:0] v;
    write_col(10'd100, 64'h0, PRG);
    read_col(10'd100, v);
    chk("R6 out of range verify", v, 64'd0);
    read_col(10'd36, v);
    chk("R6 aliased column untouched", v, ONES43);
  endtask

  task automatic t_sig;
    logic [63:0] o;
    scan(SIG, 32, 64'hDEAD_BEEF, o);
    chk("R8 R1 signature erased", o, ONES32);
    run_op(PSIG);
    scan(SIG, 32, 64'hFFFF_0F0F, o);
    chk("R8 signature stored", o, 64'hDEAD_BEEF);
    run_op(PSIG);
    scan(SIG, 32, 64'd0, o);
    chk("R8 signature AND", o, 64'hDEAD_BEEF & 64'hFFFF_0F0F);
  endtask

  task automatic t_done;
    @(negedge clk); ir_code = SDONE; rti = 1;
    chk("R2 no early effect", cfg_valid, 0);
    @(negedge clk);
    chk("R2 R11 set done", cfg_valid, 1);
    ir_code = CDONE;
    @(negedge clk);
    chk("R2 one shot per idle entry", cfg_valid, 1);
    rti = 0;
    chk("R11 no side effect on mode", prog_mode, 1);
    run_op(CDONE);
    chk("R11 clear done", cfg_valid, 0);
    run_op(SDONE);
    chk("R11 set again", cfg_valid, 1);
  endtask

  task automatic t_fuse;
    logic [63:0] v, o;
    run_op(FUSE);
    chk("R9 fuse set", read_prot, 1);
    read_col(10'd5, v);
    chk("R9 verify blocked", v, 64'd0);
    scan(SIG, 32, 64'd0, o);
    chk("R9 signature readable", o, 64'hDEAD_BEEF & 64'hFFFF_0F0F);
  endtask

  task automatic t_erase;
    logic [63:0] v, o;
    run_op(DIS);
    chk("R3 leave mode", prog_mode, 0);
    run_op(BULK);
    chk("R10 R3 erase ignored", read_prot, 1);
    run_op(EN);
    run_op(BULK);
    chk("R10 fuse cleared", read_prot, 0);
    chk("R10 done cleared", cfg_valid, 0);
    read_col(10'd5, v);
    chk("R10 column erased", v, ONES43);
    scan(SIG, 32, 64'd0, o);
    chk("R10 signature erased", o, ONES32);
  endtask

  task automatic t_bypass;
    logic [63:0] o;
    scan(8'hEE, 8, 64'hB6, o);
    chk("R12 bypass", o, {56'd0, 8'hB6 << 1} & 64'hFF);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog got=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_gate();
    t_prog();
    t_incr();
    t_range();
    t_sig();
    t_done();
    t_fuse();
    t_erase();
    t_bypass();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule